// File: doc/BRIEF.md
# Segment Register Load Checker

This block decides whether a selector may be loaded into one of the segment registers of a segmented protected-mode processor. For each request it receives the destination register, the 16-bit selector, the current privilege level, the limit of the descriptor table being indexed, and the access attributes of the descriptor already fetched for that selector: the code/data flag, the 4-bit kind field and the descriptor privilege level. It replies with either an accept or a single fault cause.

Each destination register has its own rules for null selectors, descriptor kinds and privilege. The privilege rules use the effective level, which is the numerically larger of the current level and the level the selector requests. Requests enter through a valid/ready handshake. The verdict is registered and presented one cycle after the handshake, and it is held until the consumer takes it.

Top module: `seg_load_check`

## Requirements
- R1: Destination codes are CS=0, SS=1, DS=2, ES=3, FS=4, GS=5, LDTR=6, TR=7. Fault codes are 0 none, 1 table limit, 2 null, 3 type, 4 privilege. `rsp_accept` is 1 exactly when `rsp_cause` is 0.
- R2: Selector bits [1:0] are the requested level, bit 2 is the table select and bits [15:3] are the index. If index*8+7 is greater than `req_table_limit`, the result is fault 1.
- R3: A null selector (bits [15:2] all zero) gives fault 2 for CS, SS and TR. For DS, ES, FS, GS and LDTR it is accepted, and the descriptor inputs are ignored.
- R4: CS accepts only a code descriptor (`req_desc_s`=1 and kind bit 3 = 1). Any other descriptor gives fault 3.
- R5: SS accepts only a writable data descriptor (`req_desc_s`=1, kind bit 3 = 0, kind bit 1 = 1). Any other descriptor gives fault 3.
- R6: DS, ES, FS and GS give fault 3 for a system descriptor (`req_desc_s`=0) and for a code descriptor whose read bit (kind bit 1) is clear. They accept any data descriptor and any readable code descriptor.
- R7: LDTR accepts only a system descriptor of kind 2. TR accepts only a system descriptor of kind 1 or 9. Any other descriptor gives fault 3.
- R8: The effective level is max(current level, requested level). DS, ES, FS and GS give fault 4 when the effective level is greater than the descriptor level.
- R9: SS gives fault 4 unless the effective level equals the descriptor level.
- R10: For CS with kind bit 2 clear, the descriptor level must equal the current level and the requested level must not exceed the current level. For CS with kind bit 2 set, the descriptor level must not exceed the current level, and the requested level is ignored. A violation gives fault 4.
- R11: Only the first failing check is reported, in the order table limit, null, type, privilege. LDTR and TR have no privilege check.
- R12: After reset `rsp_valid` is 0. `req_ready` is high when no verdict is held or when `rsp_ready` is high. A verdict appears one cycle after the request handshake and stays stable until `rsp_ready` takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Checker can take a request |
| req_target | input | 3 | Destination register code |
| req_selector | input | 16 | Selector to be loaded |
| req_cpl | input | 2 | Current privilege level |
| req_table_limit | input | 16 | Byte limit of the indexed descriptor table |
| req_desc_s | input | 1 | Descriptor is code/data (1) or system (0) |
| req_desc_type | input | 4 | Descriptor kind field |
| req_desc_dpl | input | 2 | Descriptor privilege level |
| rsp_valid | output | 1 | Verdict present |
| rsp_ready | input | 1 | Consumer takes the verdict |
| rsp_accept | output | 1 | Load allowed |
| rsp_cause | output | 3 | Fault code |

## Verification
The bench uses the default widths: a 16-bit selector and a 16-bit table limit. With these widths the largest index (8191) can be reached, and so can table limits set exactly at, or one below, the last byte of a descriptor entry. This lets the off-by-one edge of the limit comparison be tested from both sides. The full 2-bit privilege range allows every ordering of current, requested and descriptor levels. Randomly stalling `rsp_ready` makes the held-verdict and back-pressure paths occur between directed cases.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

    localparam int PL_W    = 2;
    localparam int KIND_W  = 4;
    localparam int FAULT_W = 3;
    localparam int TGT_W   = 3;

    typedef logic [PL_W-1:0] pl_t;

    typedef enum logic [TGT_W-1:0] {
        TGT_CS   = 3'd0,
        TGT_SS   = 3'd1,
        TGT_DS   = 3'd2,
        TGT_ES   = 3'd3,
        TGT_FS   = 3'd4,
        TGT_GS   = 3'd5,
        TGT_LDTR = 3'd6,
        TGT_TR   = 3'd7
    } seg_target_e;

    typedef enum logic [FAULT_W-1:0] {
        FLT_NONE  = 3'd0,
        FLT_LIMIT = 3'd1,
        FLT_NULL  = 3'd2,
        FLT_TYPE  = 3'd3,
        FLT_PRIV  = 3'd4
    } fault_e;

    typedef struct packed {
        logic              code_data;
        logic [KIND_W-1:0] kind;
        pl_t               dpl;
    } desc_attr_t;

    typedef struct packed {
        logic   accept;
        fault_e cause;
    } verdict_t;

    localparam int KIND_CODE_BIT = 3;
    localparam int KIND_CONF_BIT = 2;
    localparam int KIND_RW_BIT   = 1;

    localparam logic [KIND_W-1:0] KIND_LDT    = 4'h2;
    localparam logic [KIND_W-1:0] KIND_TSS_16 = 4'h1;
    localparam logic [KIND_W-1:0] KIND_TSS_32 = 4'h9;

    function automatic logic is_data_reg(seg_target_e t);
        return (t == TGT_DS) || (t == TGT_ES) || (t == TGT_FS) || (t == TGT_GS);
    endfunction

    function automatic logic null_allowed(seg_target_e t);
        return is_data_reg(t) || (t == TGT_LDTR);
    endfunction

    function automatic pl_t pl_max(pl_t a, pl_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
    import seg_chk_pkg::*;
#(
    parameter int SEL_W   = 16,
    parameter int LIMIT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               chk_en,
    input  logic [SEL_W-1:0]   selector,
    input  logic [LIMIT_W-1:0] table_limit,
    output pl_t                rpl,
    output logic               is_null,
    output logic               limit_ok
);
    localparam int CMP_W = (SEL_W > LIMIT_W) ? SEL_W : LIMIT_W;

    logic [CMP_W-1:0] last_byte;
    logic [CMP_W-1:0] lim_ext;

    always_comb begin
        rpl       = selector[PL_W-1:0];
        is_null   = (selector[SEL_W-1:2] == '0);
        last_byte = CMP_W'({selector[SEL_W-1:3], 3'b111});
        lim_ext   = CMP_W'(table_limit);
        limit_ok  = (last_byte <= lim_ext);
    end

    // A null selector addresses entry zero and must fit any table of 8 bytes or more
    p_null_fits_r3: assert property (@(posedge clk) disable iff (rst)
        (chk_en && is_null && (lim_ext >= CMP_W'(7))) |-> limit_ok);

endmodule

// File: rtl/seg_type_rules.sv
module seg_type_rules
    import seg_chk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        chk_en,
    input  seg_target_e target,
    input  desc_attr_t  attr,
    output logic        type_ok
);
    logic is_code;
    logic rw_bit;

    always_comb begin
        is_code = attr.code_data && attr.kind[KIND_CODE_BIT];
        rw_bit  = attr.kind[KIND_RW_BIT];
        unique case (target)
            TGT_CS:   type_ok = is_code;
            TGT_SS:   type_ok = attr.code_data && !attr.kind[KIND_CODE_BIT] && rw_bit;
            TGT_DS, TGT_ES, TGT_FS, TGT_GS:
                      type_ok = attr.code_data && (!attr.kind[KIND_CODE_BIT] || rw_bit);
            TGT_LDTR: type_ok = !attr.code_data && (attr.kind == KIND_LDT);
            TGT_TR:   type_ok = !attr.code_data &&
                                ((attr.kind == KIND_TSS_16) || (attr.kind == KIND_TSS_32));
            default:  type_ok = 1'b0;
        endcase
    end

    // System descriptors never pass for a register that holds code or data
    p_sys_only_tables_r7: assert property (@(posedge clk) disable iff (rst)
        (chk_en && type_ok && !attr.code_data) |-> (target inside {TGT_LDTR, TGT_TR}));

endmodule

// File: rtl/seg_priv_rules.sv
module seg_priv_rules
    import seg_chk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        chk_en,
    input  seg_target_e target,
    input  pl_t         cpl,
    input  pl_t         rpl,
    input  desc_attr_t  attr,
    output pl_t         epl,
    output logic        priv_ok
);
    logic conforming;

    always_comb begin
        epl        = pl_max(cpl, rpl);
        conforming = attr.kind[KIND_CONF_BIT];
        priv_ok    = 1'b1;
        if (is_data_reg(target)) begin
            priv_ok = (epl <= attr.dpl);
        end else if (target == TGT_SS) begin
            priv_ok = (epl == attr.dpl);
        end else if (target == TGT_CS) begin
            if (conforming)
                priv_ok = (attr.dpl <= cpl);
            else
                priv_ok = (attr.dpl == cpl) && (rpl <= cpl);
        end
    end

    // Effective level is never below either source and equals one of them
    p_epl_is_max_r8: assert property (@(posedge clk) disable iff (rst)
        chk_en |-> ((epl >= cpl) && (epl >= rpl) && ((epl == cpl) || (epl == rpl))));

    // Table registers carry no privilege check
    p_tables_no_priv_r11: assert property (@(posedge clk) disable iff (rst)
        (chk_en && (target inside {TGT_LDTR, TGT_TR})) |-> priv_ok);

endmodule

// File: rtl/seg_load_check.sv
module seg_load_check
    import seg_chk_pkg::*;
#(
    parameter int SEL_W   = 16,
    parameter int LIMIT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [2:0]         req_target,
    input  logic [SEL_W-1:0]   req_selector,
    input  logic [1:0]         req_cpl,
    input  logic [LIMIT_W-1:0] req_table_limit,
    input  logic               req_desc_s,
    input  logic [3:0]         req_desc_type,
    input  logic [1:0]         req_desc_dpl,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic               rsp_accept,
    output logic [2:0]         rsp_cause
);
    seg_target_e target;
    desc_attr_t  attr;
    pl_t         rpl;
    pl_t         epl;
    logic        is_null;
    logic        limit_ok;
    logic        type_ok;
    logic        priv_ok;
    logic        take;
    verdict_t    verdict;

    assign target    = seg_target_e'(req_target);
    assign attr      = '{code_data: req_desc_s, kind: req_desc_type, dpl: req_desc_dpl};
    assign req_ready = !rsp_valid || rsp_ready;
    assign take      = req_valid && req_ready;

    seg_sel_decode #(.SEL_W(SEL_W), .LIMIT_W(LIMIT_W)) u_decode (
        .clk         (clk),
        .rst         (rst),
        .chk_en      (req_valid),
        .selector    (req_selector),
        .table_limit (req_table_limit),
        .rpl         (rpl),
        .is_null     (is_null),
        .limit_ok    (limit_ok)
    );

    seg_type_rules u_type (
        .clk     (clk),
        .rst     (rst),
        .chk_en  (req_valid),
        .target  (target),
        .attr    (attr),
        .type_ok (type_ok)
    );

    seg_priv_rules u_priv (
        .clk     (clk),
        .rst     (rst),
        .chk_en  (req_valid),
        .target  (target),
        .cpl     (req_cpl),
        .rpl     (rpl),
        .attr    (attr),
        .epl     (epl),
        .priv_ok (priv_ok)
    );

    // Priority: table limit, null, type, privilege
    always_comb begin
        verdict = '{accept: 1'b1, cause: FLT_NONE};
        if (!limit_ok) begin
            verdict = '{accept: 1'b0, cause: FLT_LIMIT};
        end else if (is_null) begin
            if (!null_allowed(target))
                verdict = '{accept: 1'b0, cause: FLT_NULL};
        end else if (!type_ok) begin
            verdict = '{accept: 1'b0, cause: FLT_TYPE};
        end else if (!priv_ok) begin
            verdict = '{accept: 1'b0, cause: FLT_PRIV};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_accept <= 1'b0;
            rsp_cause  <= FLT_NONE;
        end else if (take) begin
            rsp_valid  <= 1'b1;
            rsp_accept <= verdict.accept;
            rsp_cause  <= verdict.cause;
        end else if (rsp_ready) begin
            rsp_valid  <= 1'b0;
        end
    end

    p_rsp_after_take_r12: assert property (@(posedge clk) disable iff (rst)
        take |=> rsp_valid);

    p_rsp_held_r12: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_accept) && $stable(rsp_cause)));

    p_accept_clean_r1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_accept == (rsp_cause == FLT_NONE)));

    p_cs_null_rejected_r3: assert property (@(posedge clk) disable iff (rst)
        (take && limit_ok && is_null && (target == TGT_CS)) |=> !rsp_accept);

endmodule

// File: tb/test_seg_load_check.sv
module test_seg_load_check;

    localparam int CLK_PERIOD = 10;
    localparam int T_CS = 0, T_SS = 1, T_DS = 2, T_ES = 3, T_FS = 4, T_GS = 5, T_LDTR = 6, T_TR = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_target = '0;
    logic [15:0] req_selector = '0;
    logic [1:0]  req_cpl = '0;
    logic [15:0] req_table_limit = '0;
    logic        req_desc_s = 1'b0;
    logic [3:0]  req_desc_type = '0;
    logic [1:0]  req_desc_dpl = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic        rsp_accept;
    logic [2:0]  rsp_cause;

    int checks = 0;
    int failures = 0;
    bit stall_mode = 1'b0;
    bit done = 1'b0;

    logic [3:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_load_check i_seg_load_check (
        .clk             (clk),
        .rst             (rst),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_target      (req_target),
        .req_selector    (req_selector),
        .req_cpl         (req_cpl),
        .req_table_limit (req_table_limit),
        .req_desc_s      (req_desc_s),
        .req_desc_type   (req_desc_type),
        .req_desc_dpl    (req_desc_dpl),
        .rsp_valid       (rsp_valid),
        .rsp_ready       (rsp_ready),
        .rsp_accept      (rsp_accept),
        .rsp_cause       (rsp_cause)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Independent model of the requirements, returns {accept, cause}
    function automatic logic [3:0] ref_model(int tgt, logic [15:0] sel, logic [1:0] cpl,
                                             logic [15:0] lim, logic s, logic [3:0] k,
                                             logic [1:0] dpl);
        int   last_b;
        logic [1:0] rq;
        logic [1:0] ef;
        logic tok;
        logic pok;
        last_b = int'(sel[15:3]) * 8 + 7;
        rq = sel[1:0];
        ef = (cpl > rq) ? cpl : rq;
        if (last_b > int'(lim)) return 4'b0_001;
        if (sel[15:2] == 14'd0) begin
            if (tgt == T_CS || tgt == T_SS || tgt == T_TR) return 4'b0_010;
            return 4'b1_000;
        end
        case (tgt)
            T_CS:   tok = s & k[3];
            T_SS:   tok = s & ~k[3] & k[1];
            T_LDTR: tok = ~s & (k == 4'd2);
            T_TR:   tok = ~s & (k == 4'd1 || k == 4'd9);
            default: tok = s & (~k[3] | k[1]);
        endcase
        if (!tok) return 4'b0_011;
        case (tgt)
            T_CS:   pok = k[2] ? (dpl <= cpl) : ((dpl == cpl) && (rq <= cpl));
            T_SS:   pok = (ef == dpl);
            T_LDTR, T_TR: pok = 1'b1;
            default: pok = (ef <= dpl);
        endcase
        return pok ? 4'b1_000 : 4'b0_100;
    endfunction

    task automatic send(int tgt, logic [15:0] sel, logic [1:0] cpl, logic [15:0] lim,
                        logic s, logic [3:0] k, logic [1:0] dpl, logic [3:0] exp, string tag);
        bit ok;
        req_valid       = 1'b1;
        req_target      = 3'(tgt);
        req_selector    = sel;
        req_cpl         = cpl;
        req_table_limit = lim;
        req_desc_s      = s;
        req_desc_type   = k;
        req_desc_dpl    = dpl;
        do begin
            @(negedge clk);
            ok = req_ready;
            if (ok) begin
                exp_q.push_back(exp);
                tag_q.push_back(tag);
            end
            @(posedge clk);
            #1;
        end while (!ok);
        req_valid = 1'b0;
    endtask

    // Directed item: expected value given by hand
    task automatic dir(int tgt, logic [15:0] sel, logic [1:0] cpl, logic [15:0] lim,
                       logic s, logic [3:0] k, logic [1:0] dpl, logic acc, logic [2:0] cause,
                       string tag);
        send(tgt, sel, cpl, lim, s, k, dpl, {acc, cause}, tag);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && rsp_valid && rsp_ready) begin
            if (exp_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R12 unexpected verdict actual=%0h expected=none",
                         {rsp_accept, rsp_cause});
            end else begin
                logic [3:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {28'd0, rsp_accept, rsp_cause}, {28'd0, e});
            end
        end
    end

    // Consumer back-pressure
    initial begin
        forever begin
            @(posedge clk);
            #1;
            rsp_ready = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        check("R12 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R12 reset req_ready", {31'd0, req_ready}, 32'd1);
        @(posedge clk);
        #1;

        // R2 table limit edge
        dir(T_DS, 16'h0010, 2'd0, 16'h0017, 1, 4'h2, 2'd3, 1, 3'd0, "R2 limit exact");
        dir(T_DS, 16'h0010, 2'd0, 16'h0016, 1, 4'h2, 2'd3, 0, 3'd1, "R2 limit one short");
        dir(T_CS, 16'hFFF8, 2'd0, 16'hFFFF, 1, 4'hA, 2'd0, 1, 3'd0, "R2 top index");
        // R3 null
        dir(T_CS,   16'h0000, 2'd0, 16'hFFFF, 1, 4'hA, 2'd0, 0, 3'd2, "R3 null CS");
        dir(T_SS,   16'h0003, 2'd3, 16'hFFFF, 1, 4'h2, 2'd3, 0, 3'd2, "R3 null SS");
        dir(T_DS,   16'h0000, 2'd3, 16'hFFFF, 0, 4'h0, 2'd0, 1, 3'd0, "R3 null DS ignored desc");
        dir(T_GS,   16'h0002, 2'd3, 16'hFFFF, 0, 4'h5, 2'd0, 1, 3'd0, "R3 null GS ignored desc");
        dir(T_LDTR, 16'h0000, 2'd0, 16'hFFFF, 1, 4'hF, 2'd0, 1, 3'd0, "R3 null LDTR");
        dir(T_TR,   16'h0000, 2'd0, 16'hFFFF, 0, 4'h9, 2'd0, 0, 3'd2, "R3 null TR");
        // R4 CS type
        dir(T_CS, 16'h0008, 2'd0, 16'hFFFF, 1, 4'h8, 2'd0, 1, 3'd0, "R4 CS exec-only code");
        dir(T_CS, 16'h0008, 2'd0, 16'hFFFF, 1, 4'h2, 2'd0, 0, 3'd3, "R4 CS data");
        dir(T_CS, 16'h0008, 2'd0, 16'hFFFF, 0, 4'hA, 2'd0, 0, 3'd3, "R4 CS system");
        // R5 SS type
        dir(T_SS, 16'h0010, 2'd0, 16'hFFFF, 1, 4'h2, 2'd0, 1, 3'd0, "R5 SS writable");
        dir(T_SS, 16'h0010, 2'd0, 16'hFFFF, 1, 4'h0, 2'd0, 0, 3'd3, "R5 SS read-only");
        dir(T_SS, 16'h0010, 2'd0, 16'hFFFF, 1, 4'hA, 2'd0, 0, 3'd3, "R5 SS code");
        // R6 data register type
        dir(T_DS, 16'h0018, 2'd0, 16'hFFFF, 1, 4'h8, 2'd3, 0, 3'd3, "R6 DS exec-only code");
        dir(T_ES, 16'h0018, 2'd0, 16'hFFFF, 1, 4'hA, 2'd3, 1, 3'd0, "R6 ES readable code");
        dir(T_FS, 16'h0018, 2'd0, 16'hFFFF, 0, 4'h2, 2'd3, 0, 3'd3, "R6 FS system");
        dir(T_GS, 16'h0018, 2'd0, 16'hFFFF, 1, 4'h0, 2'd3, 1, 3'd0, "R6 GS read-only data");
        // R7 table registers
        dir(T_LDTR, 16'h0020, 2'd0, 16'hFFFF, 0, 4'h2, 2'd0, 1, 3'd0, "R7 LDTR kind 2");
        dir(T_LDTR, 16'h0020, 2'd0, 16'hFFFF, 0, 4'h9, 2'd0, 0, 3'd3, "R7 LDTR kind 9");
        dir(T_TR,   16'h0028, 2'd0, 16'hFFFF, 0, 4'h9, 2'd0, 1, 3'd0, "R7 TR kind 9");
        dir(T_TR,   16'h0028, 2'd0, 16'hFFFF, 0, 4'h1, 2'd0, 1, 3'd0, "R7 TR kind 1");
        dir(T_TR,   16'h0028, 2'd0, 16'hFFFF, 0, 4'h2, 2'd0, 0, 3'd3, "R7 TR kind 2");
        dir(T_TR,   16'h0028, 2'd0, 16'hFFFF, 1, 4'h9, 2'd0, 0, 3'd3, "R7 TR code/data");
        // R8 data privilege
        dir(T_DS, 16'h0010, 2'd3, 16'hFFFF, 1, 4'h2, 2'd2, 0, 3'd4, "R8 CPL above DPL");
        dir(T_DS, 16'h0013, 2'd0, 16'hFFFF, 1, 4'h2, 2'd2, 0, 3'd4, "R8 RPL above DPL");
        dir(T_ES, 16'h0011, 2'd1, 16'hFFFF, 1, 4'h2, 2'd2, 1, 3'd0, "R8 EPL below DPL");
        dir(T_FS, 16'h0012, 2'd1, 16'hFFFF, 1, 4'h2, 2'd2, 1, 3'd0, "R8 EPL equal DPL");
        // R9 stack privilege
        dir(T_SS, 16'h0012, 2'd2, 16'hFFFF, 1, 4'h2, 2'd2, 1, 3'd0, "R9 SS equal");
        dir(T_SS, 16'h0012, 2'd2, 16'hFFFF, 1, 4'h2, 2'd3, 0, 3'd4, "R9 SS DPL higher");
        dir(T_SS, 16'h0012, 2'd1, 16'hFFFF, 1, 4'h2, 2'd2, 1, 3'd0, "R9 SS RPL sets EPL");
        dir(T_SS, 16'h0010, 2'd3, 16'hFFFF, 1, 4'h2, 2'd2, 0, 3'd4, "R9 SS DPL lower");
        // R10 code privilege
        dir(T_CS, 16'h0009, 2'd1, 16'hFFFF, 1, 4'hA, 2'd1, 1, 3'd0, "R10 nonconf match");
        dir(T_CS, 16'h000A, 2'd1, 16'hFFFF, 1, 4'hA, 2'd1, 0, 3'd4, "R10 nonconf RPL high");
        dir(T_CS, 16'h0009, 2'd1, 16'hFFFF, 1, 4'hA, 2'd0, 0, 3'd4, "R10 nonconf DPL differs");
        dir(T_CS, 16'h0008, 2'd3, 16'hFFFF, 1, 4'hE, 2'd0, 1, 3'd0, "R10 conf DPL below");
        dir(T_CS, 16'h000B, 2'd0, 16'hFFFF, 1, 4'hE, 2'd0, 1, 3'd0, "R10 conf RPL ignored");
        dir(T_CS, 16'h0008, 2'd1, 16'hFFFF, 1, 4'hE, 2'd2, 0, 3'd4, "R10 conf DPL above");
        // R11 priority and table registers without privilege check
        dir(T_CS,   16'h0000, 2'd0, 16'h0005, 1, 4'hA, 2'd0, 0, 3'd1, "R11 limit before null");
        dir(T_DS,   16'h0013, 2'd3, 16'hFFFF, 0, 4'h2, 2'd0, 0, 3'd3, "R11 type before priv");
        dir(T_SS,   16'h0000, 2'd0, 16'hFFFF, 0, 4'h0, 2'd3, 0, 3'd2, "R11 null before type");
        dir(T_LDTR, 16'h0023, 2'd3, 16'hFFFF, 0, 4'h2, 2'd0, 1, 3'd0, "R11 LDTR no priv");
        dir(T_TR,   16'h0028, 2'd3, 16'hFFFF, 0, 4'h9, 2'd0, 1, 3'd0, "R11 TR no priv");

        // Random mix with back-pressure (R1, R11, R12)
        stall_mode = 1'b1;
        for (int i = 0; i < 600; i++) begin
            int          tgt;
            logic [15:0] sel;
            logic [15:0] lim;
            logic [1:0]  cpl;
            logic        s;
            logic [3:0]  k;
            logic [1:0]  dpl;
            tgt = $urandom_range(0, 7);
            sel = 16'($urandom_range(0, 16'hFFFF));
            if ($urandom_range(0, 3) == 0) sel[15:2] = 14'd0;
            else sel[15:6] = 10'd0;
            lim = ($urandom_range(0, 1) == 0) ? 16'hFFFF : 16'($urandom_range(0, 600));
            cpl = 2'($urandom_range(0, 3));
            s   = 1'($urandom_range(0, 1));
            k   = 4'($urandom_range(0, 15));
            dpl = 2'($urandom_range(0, 3));
            send(tgt, sel, cpl, lim, s, k, dpl, ref_model(tgt, sel, cpl, lim, s, k, dpl),
                 "R11 random verdict");
            if ($urandom_range(0, 4) == 0) begin
                @(posedge clk);
                #1;
            end
        end
        stall_mode = 1'b0;

        for (int w = 0; w < 50 && exp_q.size() != 0; w++) begin
            @(posedge clk);
            #1;
        end
        @(negedge clk);
        check("R12 all verdicts delivered", 32'(exp_q.size()), 32'd0);
        check("R12 idle after drain", {31'd0, rsp_valid}, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule